// File: doc/BRIEF.md
# Channel Tick Generator

This block produces a count-enable strobe for each of five timer channels from a single clock. The division happens in two stages. A shared 8-bit prescaler serves a group of channels: one prescaler covers channels 0 and 1, and the other covers channels 2, 3 and 4. Each channel then has its own power-of-two divider, which counts only the pulses of its group's prescaler. A timer counter placed downstream advances once per strobe, so its rate is the clock rate divided by (prescale × divide).

Software sets the block up with two 32-bit words written through a one-cycle write port. One word holds the two prescaler fields. The other holds a 4-bit divider selector for each channel. The selector code is log2 of the divide ratio minus a base offset. That offset is a build parameter: 1 suits 16-bit timer variants and 0 suits 32-bit ones. A new setting never cuts short a count that is already running. The count finishes on the old value and then reloads with the new one.

Top module: `chan_tick_gen`

## Requirements
- R1: A synchronous active-high `rst` holds every tick output low and clears both configuration words to zero. With those zero fields, every channel first ticks on the second rising edge after `rst` is released.
- R2: Channels 0 and 1 take their prescaler from bits [7:0] of the prescale word (`cfg_addr`=0). A field value N makes that prescaler pulse once every N+1 clock cycles.
- R3: Channels 2, 3 and 4 take their prescaler from bits [15:8] of the prescale word, with the same N+1 rule.
- R4: With `DIV_BASE`=1, channel c reads its selector from bits [4c+3:4c] of the selector word (`cfg_addr`=1). Code k divides its prescaler pulses by 2^(k+1).
- R5: With `DIV_BASE`=0, code k divides by 2^k. Code 0 ticks on every prescaler pulse.
- R6: A code whose ratio would exceed 16 (k+`DIV_BASE` > 4) divides by 16.
- R7: The steady tick period of a channel is (N+1)×ratio cycles. When that period is more than one cycle, each tick lasts exactly one cycle.
- R8: A write does not alter a prescaler or divider count in progress. Each new value is used from that counter's next reload. For example, if prescaler field 0 changes from 9 to 3 just after a channel-0 tick (code 0, `DIV_BASE`=1), the next two tick intervals are 14 and 8 cycles. If instead a selector changes from code 2 to code 0 with prescaler field 0, the next two intervals are 8 and 2 cycles. No extra tick appears in either case.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Write strobe for one cycle |
| cfg_addr | input | 1 | 0 selects the prescale word, 1 selects the selector word |
| cfg_wdata | input | 32 | Write data |
| tick_o | output | 5 | One enable pulse per channel, bit c for channel c |

## Verification
The bench tries the division path with several configurations: all-zero prescalers with codes rising across the channels, two different group prescalers with mixed codes, the full 8-bit prescale of 255, and one code shared by all channels. A channel that reads the wrong group's field, a misplaced selector nibble, or a ratio that is off by one power of two each shows up as a wrong steady period. Codes 4, 5 and 15 separate clamping from wrap-around. A second instance with a zero base offset receives the same writes, which exposes any mistake in the offset. Two mid-count rewrites, one of the prescaler and one of a selector, show whether the old count is allowed to finish.

// File: rtl/chan_tick_pkg.sv
package chan_tick_pkg;
  localparam int NUM_GRP = 2;

  // Channels below the split point belong to prescaler group 0.
  function automatic int grp_of(input int ch, input int split);
    return (ch < split) ? 0 : 1;
  endfunction

  // log2 of the divide ratio after adding the base offset and clamping.
  function automatic int ratio_log(input int code, input int base, input int max_log);
    int s;
    s = code + base;
    if (s > max_log) s = max_log;
    return s;
  endfunction
endpackage

// File: rtl/chan_tick_prescaler.sv
module chan_tick_prescaler #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] reload_val,
  output logic [W-1:0] cnt_o,
  output logic         pulse_o
);
  logic [W-1:0] cnt_q;
  logic         pulse_q;

  // Down counter: it loads the live field when it reaches zero and pulses in that cycle.
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      pulse_q <= 1'b0;
    end else if (cnt_q == '0) begin
      cnt_q   <= reload_val;
      pulse_q <= 1'b1;
    end else begin
      cnt_q   <= cnt_q - W'(1);
      pulse_q <= 1'b0;
    end
  end

  assign cnt_o   = cnt_q;
  assign pulse_o = pulse_q;
endmodule

// File: rtl/chan_tick_divider.sv
module chan_tick_divider
  import chan_tick_pkg::*;
#(
  parameter int SEL_W    = 4,
  parameter int DIV_BASE = 1,
  parameter int MAX_LOG  = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             tick_o
);
  localparam int CNT_W = (MAX_LOG < 1) ? 1 : MAX_LOG;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] reload_cnt;
  logic             tick_q;

  // Convert the selector code to ratio-1 once, at reload time.
  always_comb begin
    int lg;
    int lim;
    lg         = ratio_log(int'(sel_i), DIV_BASE, MAX_LOG);
    lim        = (1 << lg) - 1;
    reload_cnt = CNT_W'(lim);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else if (step_i) begin
      if (cnt_q == '0) begin
        cnt_q  <= reload_cnt;
        tick_q <= 1'b1;
      end else begin
        cnt_q  <= cnt_q - CNT_W'(1);
        tick_q <= 1'b0;
      end
    end else begin
      tick_q <= 1'b0;
    end
  end

  assign tick_o = tick_q;
endmodule

// File: rtl/chan_tick_gen.sv
module chan_tick_gen
  import chan_tick_pkg::*;
#(
  parameter int NUM_CH   = 5,
  parameter int SPLIT    = 2,
  parameter int PRE_W    = 8,
  parameter int SEL_W    = 4,
  parameter int REG_W    = 32,
  parameter int DIV_BASE = 1,
  parameter int MAX_LOG  = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic             cfg_addr,
  input  logic [REG_W-1:0] cfg_wdata,
  output logic [NUM_CH-1:0] tick_o
);
  localparam int PRE_BITS = NUM_GRP * PRE_W;
  localparam int SEL_BITS = NUM_CH * SEL_W;

  logic [PRE_BITS-1:0]              pre_reg;
  logic [SEL_BITS-1:0]              sel_reg;
  logic [NUM_GRP-1:0][PRE_W-1:0]    pre_cnt;
  logic [NUM_GRP-1:0]               pre_pulse;
  logic [NUM_CH-1:0]                tick_d;

  // Configuration words; only the bits that are decoded are kept.
  always_ff @(posedge clk) begin
    if (rst) begin
      pre_reg <= '0;
      sel_reg <= '0;
    end else if (cfg_we) begin
      if (cfg_addr) sel_reg <= cfg_wdata[SEL_BITS-1:0];
      else          pre_reg <= cfg_wdata[PRE_BITS-1:0];
    end
  end

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_pre
    chan_tick_prescaler #(.W(PRE_W)) u_pre (
      .clk        (clk),
      .rst        (rst),
      .reload_val (pre_reg[g*PRE_W +: PRE_W]),
      .cnt_o      (pre_cnt[g]),
      .pulse_o    (pre_pulse[g])
    );
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    localparam int GRP = grp_of(c, SPLIT);
    chan_tick_divider #(
      .SEL_W    (SEL_W),
      .DIV_BASE (DIV_BASE),
      .MAX_LOG  (MAX_LOG)
    ) u_div (
      .clk    (clk),
      .rst    (rst),
      .step_i (pre_pulse[GRP]),
      .sel_i  (sel_reg[c*SEL_W +: SEL_W]),
      .tick_o (tick_d[c])
    );
  end

  assign tick_o = tick_d;
endmodule

// File: rtl/chan_tick_gen_chk.sv
module chan_tick_gen_chk
  import chan_tick_pkg::*;
#(
  parameter int NUM_CH = 5,
  parameter int PRE_W  = 8,
  parameter int SPLIT  = 2
) (
  input logic                          clk,
  input logic                          rst,
  input logic                          cfg_we,
  input logic [NUM_CH-1:0]             tick_o,
  input logic [NUM_GRP-1:0]            pre_pulse,
  input logic [NUM_GRP-1:0][PRE_W-1:0] pre_cnt
);
  // R1: on the first cycle after reset is released, no tick is visible.
  a_r1_reset_quiet: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (tick_o == '0));

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    if (grp_of(c, SPLIT) == 0) begin : g_lo
      // R2: channels of the low group tick only after a group-0 prescaler pulse.
      a_r2_tick_follows_grp0: assert property (@(posedge clk) disable iff (rst)
        tick_o[c] |-> $past(pre_pulse[0]));
    end else begin : g_hi
      // R3: channels of the high group tick only after a group-1 prescaler pulse.
      a_r3_tick_follows_grp1: assert property (@(posedge clk) disable iff (rst)
        tick_o[c] |-> $past(pre_pulse[1]));
    end
  end

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    // R7: a reload to a nonzero count cannot pulse again on the next cycle.
    a_r7_single_pulse: assert property (@(posedge clk) disable iff (rst)
      (pre_pulse[g] && pre_cnt[g] != '0) |=> !pre_pulse[g]);
    // R8: a write leaves a count in progress decrementing normally.
    a_r8_count_undisturbed: assert property (@(posedge clk) disable iff (rst)
      (cfg_we && pre_cnt[g] != '0) |=> (pre_cnt[g] == $past(pre_cnt[g]) - PRE_W'(1)));
  end
endmodule

bind chan_tick_gen chan_tick_gen_chk #(
  .NUM_CH (NUM_CH),
  .PRE_W  (PRE_W),
  .SPLIT  (SPLIT)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .cfg_we    (cfg_we),
  .tick_o    (tick_o),
  .pre_pulse (pre_pulse),
  .pre_cnt   (pre_cnt)
);

// File: tb/chan_tick_gen_test.sv
module chan_tick_gen_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic        cfg_addr = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic [4:0]  tick_a;
  logic [4:0]  tick_b;

  int runs = 0;
  int fails = 0;
  int cyc = 0;

  always #4 clk = ~clk;  // 125 MHz
  always @(posedge clk) cyc <= cyc + 1;

  chan_tick_gen #(.DIV_BASE(1)) uut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .tick_o(tick_a));

  chan_tick_gen #(.DIV_BASE(0)) uut_b0 (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .tick_o(tick_b));

  // Vector table: prescale word, selector word, expected periods per channel.
  localparam int NV = 4;
  localparam logic [31:0] V_PRE [NV] = '{32'h0000, 32'h0204, 32'h01FF, 32'h0A06};
  localparam logic [31:0] V_SEL [NV] = '{32'h43210, 32'hF2103, 32'h35021, 32'h22222};
  localparam int V_EXP1 [NV][5] = '{
    '{2, 4, 8, 16, 16}, '{80, 10, 12, 24, 48},
    '{1024, 2048, 4, 32, 32}, '{56, 56, 88, 88, 88}};
  localparam int V_EXP0 [NV][5] = '{
    '{1, 2, 4, 8, 16}, '{40, 5, 6, 12, 48},
    '{512, 1024, 2, 32, 16}, '{28, 28, 44, 44, 44}};

  int last_a [5];
  int intv_a [5];
  int last_b [5];
  int intv_b [5];

  always @(negedge clk) begin
    for (int c = 0; c < 5; c++) begin
      if (tick_a[c]) begin intv_a[c] <= cyc - last_a[c]; last_a[c] <= cyc; end
      if (tick_b[c]) begin intv_b[c] <= cyc - last_b[c]; last_b[c] <= cyc; end
    end
  end

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    runs++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  task automatic write_reg(input logic addr, input logic [31:0] data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = addr; cfg_wdata = data;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic wait_tick_a(input int c);
    @(negedge clk);
    while (!tick_a[c]) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    runs++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int t0, t1, t2;
    foreach (last_a[c]) begin last_a[c] = 0; intv_a[c] = 0; last_b[c] = 0; intv_b[c] = 0; end
    // R1: outputs low while reset is held
    repeat (3) @(negedge clk);
    chk(tick_a == 0, "R1 reset tick base1", tick_a, 0);
    chk(tick_b == 0, "R1 reset tick base0", tick_b, 0);
    rst = 1'b0;
    @(negedge clk);  // after edge 1
    chk(tick_a == 0, "R1 edge1 base1", tick_a, 0);
    @(negedge clk);  // after edge 2
    chk(tick_a == 5'h1f, "R1 first tick base1", tick_a, 5'h1f);
    chk(tick_b == 5'h1f, "R1 R5 first tick base0", tick_b, 5'h1f);
    @(negedge clk);  // after edge 3: zero fields, ratio 2 vs 1
    chk(tick_a == 0, "R1 R4 zero-field ratio2", tick_a, 0);
    chk(tick_b == 5'h1f, "R1 R5 zero-field ratio1", tick_b, 5'h1f);

    // Vector walk: steady periods for R2 R3 R4 R5 R6 R7
    for (int v = 0; v < NV; v++) begin
      write_reg(1'b0, V_PRE[v]);
      write_reg(1'b1, V_SEL[v]);
      repeat (10000) @(negedge clk);
      for (int c = 0; c < 5; c++) begin
        string tg;
        tg = (c < 2) ? "R2" : "R3";
        chk(intv_a[c] == V_EXP1[v][c],
            $sformatf("%s R4 R6 R7 vec%0d ch%0d period base1", tg, v, c), intv_a[c], V_EXP1[v][c]);
        chk(cyc - last_a[c] <= V_EXP1[v][c] + 1,
            $sformatf("%s R7 vec%0d ch%0d still ticking base1", tg, v, c), cyc - last_a[c], V_EXP1[v][c]);
        chk(intv_b[c] == V_EXP0[v][c],
            $sformatf("%s R5 R6 vec%0d ch%0d period base0", tg, v, c), intv_b[c], V_EXP0[v][c]);
      end
      if (v == 1) begin
        wait_tick_a(1);
        @(negedge clk);
        chk(tick_a[1] == 1'b0, "R7 tick width one cycle", tick_a[1], 0);
      end
    end

    // R8: prescaler change 9 -> 3 just after a channel-0 tick
    write_reg(1'b1, 32'h0);
    write_reg(1'b0, 32'h0009);
    repeat (200) @(negedge clk);
    wait_tick_a(0); t0 = cyc;
    write_reg(1'b0, 32'h0003);
    wait_tick_a(0); t1 = cyc;
    wait_tick_a(0); t2 = cyc;
    chk(t1 - t0 == 14, "R8 prescale change first interval", t1 - t0, 14);
    chk(t2 - t1 == 8, "R8 prescale change second interval", t2 - t1, 8);

    // R8: selector change code 2 -> 0 with prescale field 0
    write_reg(1'b0, 32'h0);
    write_reg(1'b1, 32'h2);
    repeat (200) @(negedge clk);
    wait_tick_a(0); t0 = cyc;
    write_reg(1'b1, 32'h0);
    wait_tick_a(0); t1 = cyc;
    wait_tick_a(0); t2 = cyc;
    chk(t1 - t0 == 8, "R8 selector change first interval", t1 - t0, 8);
    chk(t2 - t1 == 2, "R8 selector change second interval", t2 - t1, 2);

    finish_run();
  end
endmodule